// File: doc/BRIEF.md
# Affine Loop Address and Schedule Generator

This block drives a streaming memory with an address stream and a matching stream of access strobes. The access pattern is a loop nest of up to six levels. Every level has a programmable extent, an address stride and a time stride. A base address and a base start time complete the pattern. The address of one access is the base address plus the sum, over all levels, of the level's stride times its index. The scheduled issue time of that access is built the same way from the time strides and the time base.

The hardware holds no multiplier. An index counter walks the loop nest with the innermost level moving fastest. Two copies of one accumulator structure follow the counter, one producing the address and one producing the scheduled time. Each copy keeps, for every level, the value that was current when that level last moved. When a level steps, its stride is added to that saved value. A cycle counter starts at zero when a run is launched. An access is issued in any cycle where that counter has reached the scheduled time of the pending access.

Software loads the pattern through a small write-only register port while the block is idle. A start pulse launches a run. The strobe output marks each issued access, and the done flag rises after the last access of the nest.

Top module: `affine_agen`

## Requirements
- R1: After reset the block is idle. Busy, strobe and done are low, the address output is 0, and every configuration register reads as zero, so an unconfigured run issues exactly one access at address 0 in its first cycle.
- R2: The strobed addresses follow base + Σ astride[l]·idx[l], modulo 2^ADDR_W. Level 0 is the innermost level and increments on every access. The address output holds between strobes, and on launch it equals the address base.
- R3: The extent register of a level holds the last index of that level, so the level has value+1 iterations. One run issues exactly the product of (value+1) over all levels.
- R4: The cycle counter reads 0 in the first cycle after the start edge and then counts up by one per cycle. Each access has a scheduled time of tbase + Σ tstride[l]·idx[l]. It is strobed in the first cycle, not earlier than the previous strobe plus one, in which the counter is at least that time. Equal or overdue times therefore issue back to back.
- R5: Done rises in the cycle after the final strobe, together with busy falling. Done stays high until the next launch and is never high while busy.
- R6: Configuration writes and start pulses that arrive while busy have no effect on the running pattern or on the next run.
- R7: Strides are two's complement, so a negative address stride walks the address downward with wraparound.
- R8: The register select is 5 bits. Bits [4:3] pick the group: 0 = extent (last index), 1 = address stride, 2 = time stride, 3 = base. Bits [2:0] pick the level. In group 3, slot 0 is the address base and slot 1 is the time base.
- R9: No strobe is issued while idle, and at most one access is issued per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cfg_we_i | input | 1 | Configuration write enable, honoured only while idle |
| cfg_sel_i | input | 5 | Register select (group, level) |
| cfg_data_i | input | 16 | Configuration write data |
| start_i | input | 1 | Launch pulse, honoured only while idle |
| busy_o | output | 1 | A run is in progress |
| strobe_o | output | 1 | Access issued this cycle |
| addr_o | output | 16 | Address of the current or last access |
| done_o | output | 1 | The last run finished |

## Verification
The bench targets carries across several levels at once, the full six-level nest, and a negative stride that wraps below zero. A design that restored the wrong saved value on a multi-level carry would emit a wrong address right after each outer step. A design that mishandled wraparound would go off course after the first backward step. Schedules with repeated or overdue times check the catch-up rule: an exact-equality comparator would hang there, while a design without it would issue two accesses in one cycle. The bench also places the done edge at exactly one cycle after the final strobe, runs the single-access default configuration, and attempts writes and a second start during a run, which a design that did not freeze its registers would let leak into the next run.

// File: rtl/agen_pkg.sv
package agen_pkg;

    localparam int unsigned AGEN_MAX_LEVELS = 8;
    localparam int unsigned AGEN_SEL_W      = 5;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_t;

    typedef enum logic [1:0] {
        GRP_EXTENT  = 2'd0,
        GRP_ASTRIDE = 2'd1,
        GRP_TSTRIDE = 2'd2,
        GRP_ORIGIN  = 2'd3
    } cfg_grp_t;

    typedef struct packed {
        logic [AGEN_MAX_LEVELS-1:0] bump;
        logic                       final_step;
    } step_plan_t;

    function automatic cfg_grp_t sel_group(input logic [AGEN_SEL_W-1:0] sel);
        return cfg_grp_t'(sel[4:3]);
    endfunction

    function automatic logic [2:0] sel_slot(input logic [AGEN_SEL_W-1:0] sel);
        return sel[2:0];
    endfunction

endpackage

// File: rtl/agen_iter.sv
module agen_iter
    import agen_pkg::*;
#(
    parameter int LEVELS = 6,
    parameter int EXT_W  = 8
) (
    input  logic                          clk_i,
    input  logic                          rst_i,
    input  logic                          clear_i,
    input  logic                          adv_i,
    input  logic [LEVELS-1:0][EXT_W-1:0]  last_i,
    output step_plan_t                    plan_o
);

    logic [LEVELS-1:0][EXT_W-1:0] idx_q;
    logic [LEVELS:0]              carry;
    logic [LEVELS-1:0]            bump_v;
    logic [LEVELS-1:0]            wrap_v;

    assign carry[0] = 1'b1;

    generate
        for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
            logic at_end;
            assign at_end     = (idx_q[l] == last_i[l]);
            assign carry[l+1] = carry[l] & at_end;
            assign bump_v[l]  = carry[l] & ~at_end;
            assign wrap_v[l]  = carry[l] & at_end;
        end
    endgenerate

    assign plan_o = '{bump: AGEN_MAX_LEVELS'(bump_v), final_step: carry[LEVELS]};

    always_ff @(posedge clk_i) begin
        if (rst_i || clear_i) begin
            idx_q <= '0;
        end else if (adv_i) begin
            for (int l = 0; l < LEVELS; l++) begin
                if (wrap_v[l]) begin
                    idx_q[l] <= '0;
                end else if (bump_v[l]) begin
                    idx_q[l] <= idx_q[l] + EXT_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/agen_accum.sv
module agen_accum #(
    parameter int LEVELS = 6,
    parameter int W      = 16
) (
    input  logic                      clk_i,
    input  logic                      rst_i,
    input  logic                      load_i,
    input  logic                      adv_i,
    input  logic [LEVELS-1:0]         bump_i,
    input  logic [LEVELS-1:0][W-1:0]  stride_i,
    input  logic [W-1:0]              origin_i,
    output logic [W-1:0]              value_o
);

    logic [LEVELS-1:0][W-1:0] base_q;
    logic [W-1:0]             pick_base;
    logic [W-1:0]             pick_stride;
    logic [W-1:0]             next_val;
    logic [LEVELS-1:0]        reach;

    always_comb begin
        pick_base   = '0;
        pick_stride = '0;
        for (int l = 0; l < LEVELS; l++) begin
            if (bump_i[l]) begin
                pick_base   = pick_base | base_q[l];
                pick_stride = pick_stride | stride_i[l];
            end
        end
        next_val = pick_base + pick_stride;
    end

    generate
        for (genvar l = 0; l < LEVELS; l++) begin : g_reach
            assign reach[l] = |bump_i[LEVELS-1:l];
        end
    endgenerate

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            value_o <= '0;
            base_q  <= '0;
        end else if (load_i) begin
            value_o <= origin_i;
            for (int l = 0; l < LEVELS; l++) begin
                base_q[l] <= origin_i;
            end
        end else if (adv_i && (|bump_i)) begin
            value_o <= next_val;
            for (int l = 0; l < LEVELS; l++) begin
                if (reach[l]) begin
                    base_q[l] <= next_val;
                end
            end
        end
    end

endmodule

// File: rtl/affine_agen.sv
module affine_agen
    import agen_pkg::*;
#(
    parameter int LEVELS = 6,
    parameter int EXT_W  = 8,
    parameter int ADDR_W = 16,
    parameter int TIME_W = 16,
    parameter int CFG_W  = (ADDR_W > TIME_W) ? ADDR_W : TIME_W
) (
    input  logic                  clk_i,
    input  logic                  rst_i,
    input  logic                  cfg_we_i,
    input  logic [AGEN_SEL_W-1:0] cfg_sel_i,
    input  logic [CFG_W-1:0]      cfg_data_i,
    input  logic                  start_i,
    output logic                  busy_o,
    output logic                  strobe_o,
    output logic [ADDR_W-1:0]     addr_o,
    output logic                  done_o
);

    logic [LEVELS-1:0][EXT_W-1:0]  ext_q;
    logic [LEVELS-1:0][ADDR_W-1:0] astr_q;
    logic [LEVELS-1:0][TIME_W-1:0] tstr_q;
    logic [ADDR_W-1:0]             aofs_q;
    logic [TIME_W-1:0]             tofs_q;

    run_state_t        state_q;
    logic [TIME_W-1:0] cyc_q;
    logic [TIME_W-1:0] tval;
    logic              done_q;
    logic              launch;
    logic              fire;
    logic              cfg_ok;
    cfg_grp_t          grp;
    logic [2:0]        slot;
    step_plan_t        plan;

    assign grp    = sel_group(cfg_sel_i);
    assign slot   = sel_slot(cfg_sel_i);
    assign cfg_ok = cfg_we_i && (state_q == ST_IDLE);
    assign launch = start_i && (state_q == ST_IDLE);
    assign fire   = (state_q == ST_RUN) && (cyc_q >= tval);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ext_q  <= '0;
            astr_q <= '0;
            tstr_q <= '0;
            aofs_q <= '0;
            tofs_q <= '0;
        end else if (cfg_ok) begin
            for (int l = 0; l < LEVELS; l++) begin
                if (int'(slot) == l) begin
                    unique case (grp)
                        GRP_EXTENT:  ext_q[l]  <= cfg_data_i[EXT_W-1:0];
                        GRP_ASTRIDE: astr_q[l] <= cfg_data_i[ADDR_W-1:0];
                        GRP_TSTRIDE: tstr_q[l] <= cfg_data_i[TIME_W-1:0];
                        default: ;
                    endcase
                end
            end
            if (grp == GRP_ORIGIN && slot == 3'd0) aofs_q <= cfg_data_i[ADDR_W-1:0];
            if (grp == GRP_ORIGIN && slot == 3'd1) tofs_q <= cfg_data_i[TIME_W-1:0];
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_IDLE;
            cyc_q   <= '0;
            done_q  <= 1'b0;
        end else if (launch) begin
            state_q <= ST_RUN;
            cyc_q   <= '0;
            done_q  <= 1'b0;
        end else if (state_q == ST_RUN) begin
            cyc_q <= cyc_q + TIME_W'(1);
            if (fire && plan.final_step) begin
                state_q <= ST_IDLE;
                done_q  <= 1'b1;
            end
        end
    end

    agen_iter #(.LEVELS(LEVELS), .EXT_W(EXT_W)) u_iter (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .clear_i (launch),
        .adv_i   (fire),
        .last_i  (ext_q),
        .plan_o  (plan)
    );

    agen_accum #(.LEVELS(LEVELS), .W(ADDR_W)) u_addr_gen (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .load_i   (launch),
        .adv_i    (fire),
        .bump_i   (plan.bump[LEVELS-1:0]),
        .stride_i (astr_q),
        .origin_i (aofs_q),
        .value_o  (addr_o)
    );

    agen_accum #(.LEVELS(LEVELS), .W(TIME_W)) u_sched_gen (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .load_i   (launch),
        .adv_i    (fire),
        .bump_i   (plan.bump[LEVELS-1:0]),
        .stride_i (tstr_q),
        .origin_i (tofs_q),
        .value_o  (tval)
    );

    assign busy_o   = (state_q == ST_RUN);
    assign strobe_o = fire;
    assign done_o   = done_q;

endmodule

// File: rtl/agen_checks.sv
module agen_checks #(
    parameter int LEVELS = 6,
    parameter int EXT_W  = 8,
    parameter int ADDR_W = 16,
    parameter int TIME_W = 16
) (
    input logic                          clk_i,
    input logic                          rst_i,
    input logic                          busy_o,
    input logic                          strobe_o,
    input logic                          done_o,
    input logic [ADDR_W-1:0]             addr_o,
    input logic                          cfg_we_i,
    input logic [TIME_W-1:0]             cyc_q,
    input logic [LEVELS-1:0][EXT_W-1:0]  ext_q,
    input logic [LEVELS-1:0][ADDR_W-1:0] astr_q,
    input logic [LEVELS-1:0][TIME_W-1:0] tstr_q,
    input logic [ADDR_W-1:0]             aofs_q
);

    // R9: quiet while idle
    p_quiet_idle_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        !busy_o |-> !strobe_o);

    // R5: done and busy never together
    p_done_excl_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        busy_o |-> !done_o);

    // R5: done rises only right after a strobe, as busy falls
    p_done_follows_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(done_o) |-> ($past(strobe_o) && $past(busy_o) && !busy_o));

    // R2: address holds between strobes
    p_addr_hold_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (busy_o && !strobe_o) |=> $stable(addr_o));

    // R2: a run opens at the address base with the counter at zero
    p_launch_base_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(busy_o) |-> (addr_o == aofs_q && cyc_q == '0));

    // R4: counter advances by one each running cycle
    p_cycle_step_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (busy_o && $past(busy_o)) |-> (cyc_q == $past(cyc_q) + TIME_W'(1)));

    // R6: configuration frozen during a run
    p_cfg_frozen_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (busy_o && cfg_we_i) |=> ($stable(ext_q) && $stable(astr_q)
                                   && $stable(tstr_q) && $stable(aofs_q)));

endmodule

bind affine_agen agen_checks #(
    .LEVELS (LEVELS),
    .EXT_W  (EXT_W),
    .ADDR_W (ADDR_W),
    .TIME_W (TIME_W)
) u_chk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .busy_o   (busy_o),
    .strobe_o (strobe_o),
    .done_o   (done_o),
    .addr_o   (addr_o),
    .cfg_we_i (cfg_we_i),
    .cyc_q    (cyc_q),
    .ext_q    (ext_q),
    .astr_q   (astr_q),
    .tstr_q   (tstr_q),
    .aofs_q   (aofs_q)
);

// File: tb/sim_affine_agen.sv
module sim_affine_agen;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [4:0]  cfg_sel;
    logic [15:0] cfg_data;
    logic        start;
    logic        busy, strobe, done;
    logic [15:0] addr;

    int checks   = 0;
    int failures = 0;
    bit finished = 0;

    int e_last [6];
    int a_s    [6];
    int t_s    [6];
    int a_off, t_off;
    int ea [64];
    int ef [64];

    always #10 clk = ~clk;

    affine_agen u0 (
        .clk_i(clk), .rst_i(rst), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
        .cfg_data_i(cfg_data), .start_i(start), .busy_o(busy),
        .strobe_o(strobe), .addr_o(addr), .done_o(done)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic wr(input int sel, input int val);
        @(negedge clk);
        cfg_we   = 1'b1;
        cfg_sel  = 5'(sel);
        cfg_data = 16'(val);
        @(negedge clk);
        cfg_we   = 1'b0;
    endtask

    task automatic clear_cfg();
        for (int l = 0; l < 6; l++) begin
            e_last[l] = 0; a_s[l] = 0; t_s[l] = 0;
        end
        a_off = 0; t_off = 0;
    endtask

    // R8: group in sel[4:3], level in sel[2:0]
    task automatic program_all();
        for (int l = 0; l < 6; l++) begin
            wr(l, e_last[l]);
            wr(8 + l, a_s[l]);
            wr(16 + l, t_s[l]);
        end
        wr(24, a_off);
        wr(25, t_off);
    endtask

    task automatic build_expect(output int total);
        int prevf;
        total = 1;
        for (int l = 0; l < 6; l++) total = total * (e_last[l] + 1);
        prevf = -1;
        for (int n = 0; n < total; n++) begin
            int rem, ad, tm;
            rem = n; ad = a_off; tm = t_off;
            for (int l = 0; l < 6; l++) begin
                int i;
                i   = rem % (e_last[l] + 1);
                rem = rem / (e_last[l] + 1);
                ad  = ad + a_s[l] * i;
                tm  = tm + t_s[l] * i;
            end
            ea[n] = ad & 16'hFFFF;
            ef[n] = (tm > prevf + 1) ? tm : prevf + 1;
            prevf = ef[n];
        end
    endtask

    task automatic run_check(input string rq);
        int total, n, k, done_k;
        build_expect(total);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0; k = 0; done_k = -1;
        while (k < 4000) begin
            if (strobe) begin
                if (n < total) begin
                    chk(k == ef[n], "R4", {rq, " strobe cycle"}, k, ef[n]);
                    chk(int'(addr) == ea[n], "R2", {rq, " address"}, int'(addr), ea[n]);
                end
                n++;
            end
            if (done) begin
                done_k = k;
                break;
            end
            k++;
            @(negedge clk);
        end
        chk(n == total, "R3", {rq, " access count"}, n, total);
        chk(done_k == ef[total-1] + 1, "R5", {rq, " done cycle"}, done_k, ef[total-1] + 1);
        chk(!busy, "R5", {rq, " busy after done"}, int'(busy), 0);
        repeat (3) @(negedge clk);
        chk(done && !strobe, "R5", {rq, " done held, no strobe"}, int'(done), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int cnt;
        rst = 1'b1; cfg_we = 1'b0; cfg_sel = '0; cfg_data = '0; start = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(!busy && !strobe && !done, "R1", "idle outputs", int'({busy, strobe, done}), 0);
        chk(addr == 16'd0, "R1", "address after reset", int'(addr), 0);

        // R1 / R3: unconfigured run issues one access at 0
        clear_cfg();
        run_check("R1");

        // R3 / R2: three levels, strictly increasing times
        clear_cfg();
        e_last[0] = 2; e_last[1] = 1; e_last[2] = 1;
        a_s[0] = 1; a_s[1] = 4; a_s[2] = 16; a_off = 5;
        t_s[0] = 1; t_s[1] = 3; t_s[2] = 6;
        program_all();
        run_check("R2");

        // R6: writes and start during a run are ignored
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cnt = int'(strobe);
        @(negedge clk);
        cnt += int'(strobe);
        cfg_we = 1'b1; cfg_sel = 5'd8; cfg_data = 16'd9;
        chk(busy, "R6", "busy during write", int'(busy), 1);
        @(negedge clk);
        cnt += int'(strobe);
        cfg_we = 1'b0; start = 1'b1;
        @(negedge clk);
        cnt += int'(strobe);
        start = 1'b0;
        for (int w = 0; w < 100 && !done; w++) begin
            @(negedge clk);
            cnt += int'(strobe);
        end
        chk(cnt == 12, "R6", "accesses with restart attempt", cnt, 12);
        run_check("R6");

        // R7: negative address stride with wraparound, gaps in schedule
        clear_cfg();
        e_last[0] = 1; e_last[1] = 2;
        a_s[0] = -3; a_s[1] = 7; a_off = 1;
        t_s[0] = 3; t_s[1] = 10; t_off = 2;
        program_all();
        run_check("R7");

        // R4: repeated and overdue times issue back to back
        clear_cfg();
        e_last[0] = 2; e_last[1] = 1;
        a_s[0] = 2; a_s[1] = 100; a_off = 40;
        t_s[0] = 0; t_s[1] = 5;
        program_all();
        run_check("R4");

        // R8 / R3: full six-level nest, every carry depth
        clear_cfg();
        for (int l = 0; l < 6; l++) begin
            e_last[l] = 1; a_s[l] = 1 << l; t_s[l] = 1 << l;
        end
        a_off = 16'hFFF0;
        program_all();
        run_check("R8");

        // R9: single access with a delayed start time
        clear_cfg();
        a_off = 300; t_off = 4;
        program_all();
        run_check("R9");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule